// File: doc/BRIEF.md
# Configuration Word Checksum Verifier

This block checks a stream of 16-bit configuration words against the checksum word that closes the stream. Words arrive one per cycle when `word_valid` is high. The word that carries `word_last` is the checksum. All earlier words of the block are added into a wide accumulator. The checksum word itself is never added.

When the checksum word is accepted, the block compares the low 16 bits of the accumulated sum with it. A block whose full sum is zero is rejected, even when the low bits match. One cycle later the verdict appears on `pass`, together with a single-cycle `done` pulse. The accumulator then clears itself, so the next word starts a new block. A `start` pulse drops any partial block at any time.

Control is a three-state machine:
- **ST_EMPTY**: no word of the current block has been summed yet.
- **ST_SUM**: at least one data word has been summed.
- **ST_DONE**: the cycle after a checksum word was accepted; `done` is high.

Transitions:
- **T_FIRST**: ST_EMPTY or ST_DONE goes to ST_SUM on a data word.
- **T_CLOSE**: any state goes to ST_DONE on a checksum word.
- **T_IDLE**: ST_EMPTY or ST_DONE goes to ST_EMPTY when no word arrives.
- **T_ABORT**: ST_SUM goes to ST_EMPTY on `start` with no word.
- **T_HOLD**: ST_SUM stays in ST_SUM on further data words or on idle cycles.

Top module: `cfg_checksum_verifier`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `pass` are 0 and the accumulator is empty.
- R2: Every accepted word with `word_last` low is added into an accumulator of ACC_W bits (default 32). The sum wraps modulo 2^ACC_W.
- R3: The word accepted with `word_last` high is the checksum and is not added to the sum.
- R4: The verdict is pass (1) when bits 15:0 of the sum equal the checksum word and the full sum is non-zero. Otherwise the verdict is fail (0).
- R5: A full sum of zero gives fail even when its low 16 bits match the checksum. A non-zero sum whose low 16 bits are zero passes against a checksum of 0.
- R6: A block made of the checksum word alone has a zero sum and therefore fails.
- R7: `done` is high for exactly the one cycle after each checksum word is accepted, and is low at all other times. `pass` takes the new verdict in that same cycle and holds it until the next verdict.
- R8: `start` clears the accumulator and discards any partial block. A word accepted in the same cycle as `start` becomes the first word of the new block. If that word carries `word_last`, it forms a one-word block.
- R9: Cycles with `word_valid` low change neither the sum nor `pass`. A new block may begin in the cycle right after a checksum word, including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the accumulator and begins a new block |
| word_valid | input | 1 | A word is present on `word_data` this cycle |
| word_data | input | 16 | Configuration word, or the checksum when `word_last` is high |
| word_last | input | 1 | Marks the checksum word that closes the block |
| done | output | 1 | One-cycle strobe: a verdict is available |
| pass | output | 1 | Verdict of the latest block (1 = valid), held between blocks |

## Verification
Two functions can fall in the same cycle. The `start` clear can meet word acceptance, and the close of one block can meet the first word of the next. The bench drives `start` together with a data word and together with a checksum word. It also sends a data word in the very cycle `done` is high, and mixes mid-block `start` pulses into pseudo-random traffic. A behavioural reference model keeps the sum as a plain 32-bit variable that clears first and adds second. It is compared with `done` and `pass` on every clock, so any wrong priority between the clear and the addition shows up as a miscompare on the next verdict.

// File: rtl/cfgsum_pkg.sv
package cfgsum_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_SUM   = 2'd1,
        ST_DONE  = 2'd2
    } cfgsum_state_e;

endpackage

// File: rtl/cfgsum_ctrl.sv
module cfgsum_ctrl
    import cfgsum_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          take_data,
    input  logic          take_last,
    output cfgsum_state_e state,
    output logic          done
);

    cfgsum_state_e state_q;
    cfgsum_state_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY, ST_DONE: begin
                if (take_last)      state_d = ST_DONE;   // T_CLOSE
                else if (take_data) state_d = ST_SUM;    // T_FIRST
                else                state_d = ST_EMPTY;  // T_IDLE
            end
            ST_SUM: begin
                if (take_last)      state_d = ST_DONE;   // T_CLOSE
                else if (take_data) state_d = ST_SUM;    // T_HOLD (new block if start)
                else if (start)     state_d = ST_EMPTY;  // T_ABORT
                else                state_d = ST_SUM;    // T_HOLD
            end
            default:                state_d = ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output logic: done is a registered (Moore) output of the state.
    always_comb begin
        done = 1'b0;
        unique case (state_q)
            ST_DONE:         done = 1'b1;
            ST_EMPTY, ST_SUM: done = 1'b0;
            default:         done = 1'b0;
        endcase
    end

    assign state = state_q;

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_last |=> done);
    assert_done_only_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_last |=> !done);
    assert_data_leaves_sum_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_data && !take_last) |=> (state == ST_SUM));

endmodule

// File: rtl/cfgsum_acc.sv
module cfgsum_acc #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic              end_en,
    input  logic [DATA_W-1:0] din,
    output logic [ACC_W-1:0]  base,
    output logic [ACC_W-1:0]  acc_q
);

    localparam int PAD_W = ACC_W - DATA_W;

    logic [ACC_W-1:0] din_ext;
    logic [ACC_W-1:0] acc_d;

    assign din_ext = {{PAD_W{1'b0}}, din};

    // The clear takes effect before the addition in the same cycle.
    assign base = clear ? '0 : acc_q;

    always_comb begin
        if (end_en)      acc_d = '0;
        else if (add_en) acc_d = base + din_ext;
        else             acc_d = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !add_en) |=> (acc_q == '0));
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !add_en && !end_en) |=> $stable(acc_q));
    assert_adds_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clear && !end_en) |=> (acc_q == $past(acc_q) + $past(din_ext)));
    assert_checksum_not_added_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_en |=> (acc_q == '0));

endmodule

// File: rtl/cfgsum_judge.sv
module cfgsum_judge #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decide,
    input  logic [ACC_W-1:0]  sum,
    input  logic [DATA_W-1:0] check_word,
    output logic              pass_q
);

    logic low_match;
    logic sum_nonzero;
    logic verdict;

    assign low_match   = (sum[DATA_W-1:0] == check_word);
    assign sum_nonzero = |sum;
    assign verdict     = low_match && sum_nonzero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pass_q <= 1'b0;
        else if (decide) pass_q <= verdict;
    end

    assert_pass_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !decide |=> $stable(pass_q));
    assert_zero_sum_fails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && (sum == '0)) |=> !pass_q);
    assert_mismatch_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && (sum[DATA_W-1:0] != check_word)) |=> !pass_q);

endmodule

// File: rtl/cfg_checksum_verifier.sv
module cfg_checksum_verifier
    import cfgsum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_last,
    output logic              done,
    output logic              pass
);

    logic             take_data;
    logic             take_last;
    logic [ACC_W-1:0] sum_base;
    logic [ACC_W-1:0] acc_q;
    cfgsum_state_e    state;

    assign take_data = word_valid && !word_last;
    assign take_last = word_valid && word_last;

    cfgsum_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .take_data (take_data),
        .take_last (take_last),
        .state     (state),
        .done      (done)
    );

    cfgsum_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .add_en (take_data),
        .end_en (take_last),
        .din    (word_data),
        .base   (sum_base),
        .acc_q  (acc_q)
    );

    cfgsum_judge #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .decide     (take_last),
        .sum        (sum_base),
        .check_word (word_data),
        .pass_q     (pass)
    );

    assert_empty_state_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (acc_q == '0));
    assert_one_word_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_last && (start || state != ST_SUM)) |=> (done && !pass));

endmodule

// File: tb/cfg_checksum_verifier_test.sv
`timescale 1ns/1ps
module cfg_checksum_verifier_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_last = 1'b0;
    logic        done;
    logic        pass;

    int    vectors = 0;
    int    fails = 0;
    bit    finished = 0;
    string cur_req = "R1";
    string exp_tag = "R1";

    // Reference model state.
    logic [31:0] m_sum = '0;
    logic        exp_done = 1'b0;
    logic        exp_pass = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    cfg_checksum_verifier uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_valid(word_valid),
        .word_data(word_data), .word_last(word_last), .done(done), .pass(pass)
    );

    // Behavioural reference: clear first, then add or decide.
    always @(posedge clk) begin
        exp_tag = cur_req;
        if (!rst_n) begin
            m_sum = '0; exp_done = 1'b0; exp_pass = 1'b0;
        end else begin
            if (start) m_sum = '0;
            exp_done = 1'b0;
            if (word_valid) begin
                if (word_last) begin
                    exp_pass = (m_sum[15:0] == word_data) && (m_sum != 0);
                    exp_done = 1'b1;
                    m_sum = '0;
                end else begin
                    m_sum = m_sum + 32'(word_data);
                end
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            vectors++;
            if (done !== exp_done || pass !== exp_pass) begin
                fails++;
                $display("FAIL %s t=%0t done=%b pass=%b expected done=%b pass=%b",
                         exp_tag, $time, done, pass, exp_done, exp_pass);
            end
        end
    end

    task automatic put(input bit s, input bit v, input logic [15:0] d, input bit l);
        @(negedge clk);
        start = s; word_valid = v; word_data = d; word_last = l;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, 0, 16'h0, 0);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic summary();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R4: basic pass; checksum word excluded (6, not 12).
        cur_req = "R2_R3_R4";
        put(0, 1, 16'd1, 0); put(0, 1, 16'd2, 0); put(0, 1, 16'd3, 0); put(0, 1, 16'd6, 1);
        idle(2);
        // R4: mismatch fails.
        cur_req = "R4";
        put(0, 1, 16'h1234, 0); put(0, 1, 16'h0001, 0); put(0, 1, 16'h1236, 1);
        idle(2);
        // R5: all-zero words, checksum 0 -> fail.
        cur_req = "R5";
        put(0, 1, 16'h0, 0); put(0, 1, 16'h0, 0); put(0, 1, 16'h0, 1);
        idle(1);
        // R5: sum 0x10000, low bits zero, checksum 0 -> pass.
        put(0, 1, 16'h8000, 0); put(0, 1, 16'h8000, 0); put(0, 1, 16'h0, 1);
        idle(2);
        // R6: one-word block fails.
        cur_req = "R6";
        put(0, 1, 16'h0, 1); idle(2);
        put(0, 1, 16'h5A5A, 1); idle(2);
        // R8: start with a data word restarts the block.
        cur_req = "R8";
        put(0, 1, 16'd5, 0); put(0, 1, 16'd6, 0); put(1, 1, 16'd9, 0); put(0, 1, 16'd9, 1);
        idle(2);
        // R8: start alone mid-block, then a fresh block.
        put(0, 1, 16'd40, 0); put(1, 0, 16'd0, 0); put(0, 1, 16'd7, 0); put(0, 1, 16'd7, 1);
        idle(2);
        // R8: start together with the checksum word -> one-word block, fail.
        put(0, 1, 16'd3, 0); put(1, 1, 16'd3, 1);
        idle(2);
        // R9: gaps inside a block do not disturb sum or pass.
        cur_req = "R9";
        put(0, 1, 16'd10, 0); idle(3); put(0, 1, 16'd20, 0); idle(2); put(0, 1, 16'd30, 1);
        idle(3);
        // R7 R9: back-to-back blocks, new word during the done cycle.
        cur_req = "R7_R9";
        put(0, 1, 16'd4, 0); put(0, 1, 16'd4, 1); put(0, 1, 16'd8, 0); put(0, 1, 16'd9, 1);
        put(0, 1, 16'd1, 0); put(0, 1, 16'd1, 1);
        idle(3);
        // R2: large words exercising carries above bit 15.
        cur_req = "R2";
        put(0, 1, 16'hFFFF, 0); put(0, 1, 16'hFFFF, 0); put(0, 1, 16'hFFFF, 0);
        put(0, 1, 16'hFFFD, 1);
        idle(2);

        // Pseudo-random traffic, mixed verdicts, starts and gaps.
        cur_req = "R2_R4_R8";
        for (int b = 0; b < 60; b++) begin
            logic [15:0] s;
            int len;
            s = '0;
            step_lfsr();
            len = 1 + (lfsr % 6);
            for (int w = 0; w < len - 1; w++) begin
                step_lfsr();
                s = s + lfsr;
                put((lfsr[3:0] == 4'h5), 1, lfsr, 0);
                if (lfsr[7]) idle(1);
            end
            step_lfsr();
            put(0, 1, lfsr[0] ? s : lfsr, 1);
            if (lfsr[9]) idle(1);
        end
        idle(4);
        summary();
    end

endmodule